// File: doc/BRIEF.md
# Coprocessor Issue and Result Controller

This block joins a small in-order 32-bit pipeline to a single attached coprocessor. When the decode stage holds an instruction whose major opcode marks it as a coprocessor operation, the controller captures the whole 32-bit word and the two source register values read for it. It then offers them to the coprocessor over a valid/ready request port. The coprocessor gets the raw word, so it can decode the word in a format of its own. The pipeline moves on as soon as the word is captured. A second coprocessor instruction that reaches decode while one is still outstanding is held there, which keeps coprocessor operations in program order.

The coprocessor answers with one response. That response may ask for a write of any general-purpose register and may supply a jump target that replaces the next fetch address. Both are presented to the pipeline one cycle after the response. While the coprocessor raises its hold line, the controller freezes the pipeline. A pipeline flush cancels any coprocessor operation that is offered or outstanding, and a cancelled operation leaves no write and no jump. If a coprocessor opcode appears while no coprocessor is fitted, the controller raises a reserved-instruction exception instead of issuing.

The controller has three states. IDLE waits for a coprocessor instruction. OFFER drives the request until the coprocessor takes it. BUSY waits for the response. The transitions are:

- IDLE to OFFER on capture.
- OFFER to BUSY on the handshake.
- OFFER to IDLE on a flush.
- BUSY to IDLE on a response.
- BUSY to IDLE on a flush.

Top module: `cop_if_ctrl`

## Requirements
- R1: After reset, no request is offered and no write, jump, exception or cancel is signalled.
- R2: A coprocessor instruction (bits 31:26 equal to 0x12) that is valid in decode while the controller is IDLE, with a coprocessor fitted and no flush, is offered on the cycle after capture: `cop_req_valid` is high, `cop_req_instr` carries the full 32-bit word, and the operand ports carry both source values.
- R3: Until `cop_req_ready` is seen, the offered request stays valid with an unchanged payload. In the cycle after the handshake the request is withdrawn, so each instruction is taken exactly once.
- R4: An instruction with any other value in bits 31:26 is neither offered nor flagged.
- R5: A coprocessor opcode seen while `cop_present` is low raises `resv_instr_exc` for exactly one cycle, on the cycle after decode, and offers no request.
- R6: A response in BUSY with write enable set and a non-zero register number produces `wb_en` one cycle later, together with that register number and the data.
- R7: A response write that targets register 0 produces no `wb_en`.
- R8: A response with its jump flag set produces `redirect_en` one cycle later, together with the supplied target address.
- R9: While `cop_hold` is high and there is no flush, `pipe_stall` is high in the same cycle.
- R10: A flush while an operation is offered or in BUSY raises `cop_cancel` in that cycle and returns the controller to IDLE. A response that arrives in the flush cycle produces no write and no jump.
- R11: When a flush and a stall request share a cycle, `pipe_stall` is low.
- R12: A coprocessor instruction that reaches decode while an earlier one is outstanding raises `pipe_stall`. It is captured and offered after the earlier operation completes.
- R13: A response that arrives while the controller is not in BUSY is ignored and produces no write and no jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode stage holds a valid instruction |
| id_instr | input | 32 | Instruction word in decode |
| id_opa | input | 32 | First source register value |
| id_opb | input | 32 | Second source register value |
| cop_present | input | 1 | A coprocessor is fitted |
| pipe_flush | input | 1 | Pipeline flush request |
| pipe_stall | output | 1 | Freeze the pipeline this cycle |
| resv_instr_exc | output | 1 | Reserved-instruction exception pulse |
| cop_req_valid | output | 1 | Request offered to the coprocessor |
| cop_req_ready | input | 1 | Coprocessor takes the request |
| cop_req_instr | output | 32 | Raw instruction word forwarded |
| cop_req_opa | output | 32 | First operand forwarded |
| cop_req_opb | output | 32 | Second operand forwarded |
| cop_cancel | output | 1 | Outstanding coprocessor work is dropped |
| cop_hold | input | 1 | Coprocessor asks for a pipeline stall |
| cop_rsp_valid | input | 1 | Coprocessor response present |
| cop_rsp_wb | input | 1 | Response asks for a register write |
| cop_rsp_rd | input | 5 | Destination register number |
| cop_rsp_data | input | 32 | Value to write |
| cop_rsp_jump | input | 1 | Response asks for a jump |
| cop_rsp_target | input | 32 | Jump target address |
| wb_en | output | 1 | Register write strobe |
| wb_addr | output | 5 | Register written |
| wb_data | output | 32 | Value written |
| redirect_en | output | 1 | Replace the next fetch address |
| redirect_pc | output | 32 | New fetch address |

## Verification
The results fall into two timing groups. `pipe_stall` and `cop_cancel` are combinational, so they are checked one time step after the inputs change in the same cycle. The offered request, `resv_instr_exc`, `wb_en` and `redirect_en` each pass through exactly one register after the stimulus. Inputs are driven at a falling edge and these outputs are read at the next falling edge, once the single rising edge in between has registered them. The handshake, the flush and the in-order hold each take several of these steps, and every step in such a sequence is checked at the falling edge where it is due.

// File: rtl/cop_if_pkg.sv
package cop_if_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_BUSY  = 2'd2
    } cif_state_e;
endpackage

// File: rtl/cif_classify.sv
module cif_classify #(
    parameter int XLEN    = 32,
    parameter int OPC_W   = 6,
    parameter logic [OPC_W-1:0] COP_OPC = 6'h12
) (
    input  logic            id_valid,
    input  logic [XLEN-1:0] id_instr,
    input  logic            cop_present,
    input  logic            idle,
    input  logic            flush,
    output logic            take,
    output logic            resv_hit,
    output logic            order_block
);
    localparam int OPC_LSB = XLEN - OPC_W;

    logic is_cop;

    always_comb begin
        is_cop      = id_valid && (id_instr[XLEN-1:OPC_LSB] == COP_OPC);
        take        = is_cop && cop_present && idle && !flush;
        resv_hit    = is_cop && !cop_present && idle && !flush;
        order_block = is_cop && !idle;
    end
endmodule

// File: rtl/cif_fsm.sv
module cif_fsm
    import cop_if_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic req_ready,
    input  logic rsp_valid,
    input  logic flush,
    output logic idle,
    output logic req_valid,
    output logic rsp_done
);
    cif_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take) state_d = ST_OFFER;
            ST_OFFER: begin
                if (flush)          state_d = ST_IDLE;
                else if (req_ready) state_d = ST_BUSY;
            end
            ST_BUSY:  if (flush || rsp_valid) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        idle      = (state_q == ST_IDLE);
        req_valid = (state_q == ST_OFFER);
        rsp_done  = (state_q == ST_BUSY) && rsp_valid && !flush;
    end
endmodule

// File: rtl/cif_result.sv
module cif_result #(
    parameter int XLEN   = 32,
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_done,
    input  logic              rsp_wb,
    input  logic [REG_AW-1:0] rsp_rd,
    input  logic [XLEN-1:0]   rsp_data,
    input  logic              rsp_jump,
    input  logic [XLEN-1:0]   rsp_target,
    input  logic              resv_hit,
    output logic              wb_en,
    output logic [REG_AW-1:0] wb_addr,
    output logic [XLEN-1:0]   wb_data,
    output logic              redirect_en,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              resv_exc
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_en       <= 1'b0;
            wb_addr     <= '0;
            wb_data     <= '0;
            redirect_en <= 1'b0;
            redirect_pc <= '0;
            resv_exc    <= 1'b0;
        end else begin
            wb_en       <= rsp_done && rsp_wb && (rsp_rd != '0);
            redirect_en <= rsp_done && rsp_jump;
            resv_exc    <= resv_hit;
            if (rsp_done) begin
                wb_addr     <= rsp_rd;
                wb_data     <= rsp_data;
                redirect_pc <= rsp_target;
            end
        end
    end
endmodule

// File: rtl/cop_if_ctrl.sv
module cop_if_ctrl #(
    parameter int XLEN   = 32,
    parameter int REG_AW = 5,
    parameter int OPC_W  = 6,
    parameter logic [OPC_W-1:0] COP_OPC = 6'h12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_valid,
    input  logic [XLEN-1:0]   id_instr,
    input  logic [XLEN-1:0]   id_opa,
    input  logic [XLEN-1:0]   id_opb,
    input  logic              cop_present,
    input  logic              pipe_flush,
    output logic              pipe_stall,
    output logic              resv_instr_exc,
    output logic              cop_req_valid,
    input  logic              cop_req_ready,
    output logic [XLEN-1:0]   cop_req_instr,
    output logic [XLEN-1:0]   cop_req_opa,
    output logic [XLEN-1:0]   cop_req_opb,
    output logic              cop_cancel,
    input  logic              cop_hold,
    input  logic              cop_rsp_valid,
    input  logic              cop_rsp_wb,
    input  logic [REG_AW-1:0] cop_rsp_rd,
    input  logic [XLEN-1:0]   cop_rsp_data,
    input  logic              cop_rsp_jump,
    input  logic [XLEN-1:0]   cop_rsp_target,
    output logic              wb_en,
    output logic [REG_AW-1:0] wb_addr,
    output logic [XLEN-1:0]   wb_data,
    output logic              redirect_en,
    output logic [XLEN-1:0]   redirect_pc
);
    logic take, resv_hit, order_block, idle, rsp_done;

    cif_classify #(.XLEN(XLEN), .OPC_W(OPC_W), .COP_OPC(COP_OPC)) u_cls (
        .id_valid    (id_valid),
        .id_instr    (id_instr),
        .cop_present (cop_present),
        .idle        (idle),
        .flush       (pipe_flush),
        .take        (take),
        .resv_hit    (resv_hit),
        .order_block (order_block)
    );

    cif_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .req_ready (cop_req_ready),
        .rsp_valid (cop_rsp_valid),
        .flush     (pipe_flush),
        .idle      (idle),
        .req_valid (cop_req_valid),
        .rsp_done  (rsp_done)
    );

    cif_result #(.XLEN(XLEN), .REG_AW(REG_AW)) u_res (
        .clk         (clk),
        .rst_n       (rst_n),
        .rsp_done    (rsp_done),
        .rsp_wb      (cop_rsp_wb),
        .rsp_rd      (cop_rsp_rd),
        .rsp_data    (cop_rsp_data),
        .rsp_jump    (cop_rsp_jump),
        .rsp_target  (cop_rsp_target),
        .resv_hit    (resv_hit),
        .wb_en       (wb_en),
        .wb_addr     (wb_addr),
        .wb_data     (wb_data),
        .redirect_en (redirect_en),
        .redirect_pc (redirect_pc),
        .resv_exc    (resv_instr_exc)
    );

    // Payload captured once per instruction, held while offered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cop_req_instr <= '0;
            cop_req_opa   <= '0;
            cop_req_opb   <= '0;
        end else if (take) begin
            cop_req_instr <= id_instr;
            cop_req_opa   <= id_opa;
            cop_req_opb   <= id_opb;
        end
    end

    always_comb begin
        pipe_stall = (cop_hold || order_block) && !pipe_flush;
        cop_cancel = pipe_flush && !idle;
    end
endmodule

// File: rtl/cop_if_ctrl_chk.sv
module cop_if_ctrl_chk #(
    parameter int XLEN   = 32,
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pipe_flush,
    input logic              pipe_stall,
    input logic              cop_hold,
    input logic              resv_instr_exc,
    input logic              cop_req_valid,
    input logic              cop_req_ready,
    input logic [XLEN-1:0]   cop_req_instr,
    input logic              cop_cancel,
    input logic              wb_en,
    input logic [REG_AW-1:0] wb_addr,
    input logic              redirect_en
);
    a_r3_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_req_valid && !cop_req_ready && !pipe_flush) |=> (cop_req_valid && $stable(cop_req_instr)));

    a_r3_single_take: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_req_valid && cop_req_ready) |=> !cop_req_valid);

    a_r5_exc_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        resv_instr_exc |-> !cop_req_valid);

    a_r7_no_reg_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_addr != '0));

    a_r9_hold_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_hold && !pipe_flush) |-> pipe_stall);

    a_r10_cancel_silent: assert property (@(posedge clk) disable iff (!rst_n)
        cop_cancel |=> (!wb_en && !redirect_en && !cop_req_valid));

    a_r11_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_flush |-> !pipe_stall);
endmodule

bind cop_if_ctrl cop_if_ctrl_chk #(.XLEN(XLEN), .REG_AW(REG_AW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pipe_flush     (pipe_flush),
    .pipe_stall     (pipe_stall),
    .cop_hold       (cop_hold),
    .resv_instr_exc (resv_instr_exc),
    .cop_req_valid  (cop_req_valid),
    .cop_req_ready  (cop_req_ready),
    .cop_req_instr  (cop_req_instr),
    .cop_cancel     (cop_cancel),
    .wb_en          (wb_en),
    .wb_addr        (wb_addr),
    .redirect_en    (redirect_en)
);

// File: tb/tb_cop_if_ctrl.sv
module tb_cop_if_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        id_valid;
    logic [31:0] id_instr, id_opa, id_opb;
    logic        cop_present, pipe_flush, pipe_stall, resv_instr_exc;
    logic        cop_req_valid, cop_req_ready;
    logic [31:0] cop_req_instr, cop_req_opa, cop_req_opb;
    logic        cop_cancel, cop_hold, cop_rsp_valid, cop_rsp_wb, cop_rsp_jump;
    logic [4:0]  cop_rsp_rd, wb_addr;
    logic [31:0] cop_rsp_data, cop_rsp_target, wb_data, redirect_pc;
    logic        wb_en, redirect_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cop_if_ctrl dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        id_valid = 0; id_instr = '0; id_opa = '0; id_opb = '0;
        pipe_flush = 0; cop_req_ready = 0; cop_hold = 0;
        cop_rsp_valid = 0; cop_rsp_wb = 0; cop_rsp_rd = '0;
        cop_rsp_data = '0; cop_rsp_jump = 0; cop_rsp_target = '0;
    endtask

    // Capture an instruction and have it taken; leaves the controller in BUSY
    task automatic issue_taken(input logic [31:0] w);
        @(negedge clk);
        id_valid = 1; id_instr = w; id_opa = 32'h1111_0000; id_opb = 32'h0000_2222;
        @(negedge clk);
        id_valid = 0; cop_req_ready = 1;
        @(negedge clk);
        cop_req_ready = 0;
    endtask

    task automatic t_reset();
        chk("R1 req_valid", cop_req_valid, 0);
        chk("R1 wb_en", wb_en, 0);
        chk("R1 redirect_en", redirect_en, 0);
        chk("R1 exc", resv_instr_exc, 0);
        chk("R1 cancel", cop_cancel, 0);
    endtask

    task automatic t_issue_write();
        @(negedge clk);
        id_valid = 1; id_instr = 32'h4812_3456; id_opa = 32'hDEAD_BEEF; id_opb = 32'h0BAD_F00D;
        @(negedge clk);
        id_valid = 0;
        chk("R2 req_valid", cop_req_valid, 1);
        chk("R2 instr", cop_req_instr, 32'h4812_3456);
        chk("R2 opa", cop_req_opa, 32'hDEAD_BEEF);
        chk("R2 opb", cop_req_opb, 32'h0BAD_F00D);
        @(negedge clk);
        chk("R3 still valid", cop_req_valid, 1);
        chk("R3 payload stable", cop_req_instr, 32'h4812_3456);
        cop_req_ready = 1;
        @(negedge clk);
        cop_req_ready = 0;
        chk("R3 withdrawn after take", cop_req_valid, 0);
        cop_rsp_valid = 1; cop_rsp_wb = 1; cop_rsp_rd = 5'd5; cop_rsp_data = 32'hCAFE_0005;
        @(negedge clk);
        idle_inputs();
        chk("R6 wb_en", wb_en, 1);
        chk("R6 wb_addr", {27'd0, wb_addr}, 32'd5);
        chk("R6 wb_data", wb_data, 32'hCAFE_0005);
        @(negedge clk);
        chk("R6 one cycle", wb_en, 0);
    endtask

    task automatic t_write_r0();
        issue_taken(32'h4800_0001);
        cop_rsp_valid = 1; cop_rsp_wb = 1; cop_rsp_rd = 5'd0; cop_rsp_data = 32'h1234_5678;
        @(negedge clk);
        idle_inputs();
        chk("R7 no write to r0", wb_en, 0);
        chk("R7 no redirect", redirect_en, 0);
    endtask

    task automatic t_jump();
        issue_taken(32'h4800_0002);
        cop_rsp_valid = 1; cop_rsp_jump = 1; cop_rsp_target = 32'h0000_4000;
        @(negedge clk);
        idle_inputs();
        chk("R8 redirect_en", redirect_en, 1);
        chk("R8 redirect_pc", redirect_pc, 32'h0000_4000);
        chk("R8 no write", wb_en, 0);
    endtask

    task automatic t_noncop();
        @(negedge clk);
        id_valid = 1; id_instr = 32'h2108_0004;
        @(negedge clk);
        id_valid = 0;
        chk("R4 not offered", cop_req_valid, 0);
        chk("R4 no exception", resv_instr_exc, 0);
    endtask

    task automatic t_reserved();
        @(negedge clk);
        cop_present = 0; id_valid = 1; id_instr = 32'h4BFF_0000;
        @(negedge clk);
        id_valid = 0; cop_present = 1;
        chk("R5 exception raised", resv_instr_exc, 1);
        chk("R5 nothing offered", cop_req_valid, 0);
        @(negedge clk);
        chk("R5 single pulse", resv_instr_exc, 0);
        chk("R5 still nothing offered", cop_req_valid, 0);
    endtask

    task automatic t_stall();
        @(negedge clk);
        cop_hold = 1;
        #1 chk("R9 stall follows hold", pipe_stall, 1);
        pipe_flush = 1;
        #1 chk("R11 flush beats stall", pipe_stall, 0);
        @(negedge clk);
        idle_inputs();
        #1 chk("R9 released", pipe_stall, 0);
    endtask

    task automatic t_flush();
        // flush while offered drops the request
        @(negedge clk);
        id_valid = 1; id_instr = 32'h4800_00AA;
        @(negedge clk);
        id_valid = 0; pipe_flush = 1;
        #1 chk("R10 cancel while offered", cop_cancel, 1);
        @(negedge clk);
        pipe_flush = 0;
        chk("R10 request dropped", cop_req_valid, 0);
        // flush in BUSY with a response in the same cycle
        issue_taken(32'h4800_00BB);
        pipe_flush = 1; cop_rsp_valid = 1; cop_rsp_wb = 1; cop_rsp_rd = 5'd7;
        cop_rsp_jump = 1; cop_rsp_target = 32'h0000_8000;
        #1 chk("R10 cancel in busy", cop_cancel, 1);
        @(negedge clk);
        pipe_flush = 0;
        chk("R10 no write after flush", wb_en, 0);
        chk("R10 no jump after flush", redirect_en, 0);
        // controller now IDLE; a stray response must be ignored
        @(negedge clk);
        idle_inputs();
        chk("R13 stray response no write", wb_en, 0);
        chk("R13 stray response no jump", redirect_en, 0);
    endtask

    task automatic t_order();
        issue_taken(32'h4800_0011);
        id_valid = 1; id_instr = 32'h4800_0022;
        #1 chk("R12 second held", pipe_stall, 1);
        cop_rsp_valid = 1; cop_rsp_wb = 1; cop_rsp_rd = 5'd3; cop_rsp_data = 32'h3;
        @(negedge clk);
        cop_rsp_valid = 0; cop_rsp_wb = 0;
        chk("R12 first completes", wb_en, 1);
        #1 chk("R12 hold released", pipe_stall, 0);
        @(negedge clk);
        id_valid = 0;
        chk("R12 second offered", cop_req_valid, 1);
        chk("R12 second word", cop_req_instr, 32'h4800_0022);
        cop_req_ready = 1;
        @(negedge clk);
        cop_req_ready = 0; cop_rsp_valid = 1;
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        cop_present = 1;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_issue_write();
        t_write_r0();
        t_jump();
        t_noncop();
        t_reserved();
        t_stall();
        t_flush();
        t_order();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule